// File: doc/BRIEF.md
# World-Tagged Set-Associative Data Cache

This block is a small write-back data cache for a processor that runs in one of two security worlds. Beside its address tag, each line records which world allocated it, and that world bit takes part in the hit comparison. The same physical address seen from the secure world and from the normal world therefore maps to two unrelated lines, and the cache holds a separate view of memory for each world. Since the world bit is compared on every lookup, a change of world needs no flush or invalidation. Lines from both worlds coexist in every set and compete for the same ways.

The processor side presents one word access at a time: an address, a store flag, store data and its current world bit (`cpu_ns`: 1 is the normal world, 0 is the secure world). `cpu_ready` tells it when the access completes. The memory side moves whole lines. A fill or a write-back is one request held until a one-cycle acknowledge. Each request carries a world bit, so memory and downstream filters can keep the worlds apart. A fill is tagged with the requester's world. A write-back is tagged with the world stored in the evicted line.

In the default configuration, a 16-bit byte address splits into tag `[15:8]`, set `[7:4]`, word `[3:2]` and ignored byte lane `[1:0]`. There are 4 ways, 16 sets and 16-byte lines of four 32-bit words.

Top module: `wtc_cache`

## Requirements
- R1: After reset is released, the cache invalidates one set per cycle for SETS cycles and holds `cpu_ready` low the whole time. While reset is asserted, `mem_req` stays low. After the sweep every line is invalid, so the first access to any address misses.
- R2: A lookup hits only when a valid line in the addressed set matches both the address tag and `cpu_ns`. At most one way hits.
- R3: An address already cached for one world misses when the other world accesses it. The other world gets its own line, filled from memory under its own world bit, and each world reads back only its own data and stores.
- R4: Switching `cpu_ns` between accesses removes nothing. Lines of both worlds that were resident before the switch still hit afterwards, with no memory traffic.
- R5: A fill request drives `mem_req`=1 and `mem_we`=0. It carries `mem_line` = address bits `[15:4]` of the access and `mem_ns` = `cpu_ns`.
- R6: A miss whose victim line is valid and dirty first issues a write-back with `mem_we`=1. The write-back carries that line's stored tag and set as `mem_line`, its stored world bit as `mem_ns` (whatever the current world) and its full contents as `mem_wdata`. The fill follows.
- R7: `mem_req` stays high until the cycle in which `mem_ack` is sampled high, and each acknowledge completes exactly one line transfer.
- R8: A hit completes in the cycle it is presented, with `cpu_ready` high in that cycle. On a miss `cpu_ready` stays low through any write-back and fill. The access completes in the cycle after the fill's acknowledge.
- R9: A store that hits writes the 32-bit word selected by address bits `[3:2]`, marks the line dirty and causes no memory traffic. A store that misses first allocates the line with a fill, then writes the word.
- R10: Each set has a round-robin victim pointer, cleared to way 0 by reset. The pointer advances by one, wrapping after the last way, on every fill from either world, so a fill may evict a line of the other world.
- R11: A victim that is invalid or clean is replaced without a write-back.
- R12: Read data is word `i` = address bits `[3:2]` of the line, taken from line bits `[32*i+31 : 32*i]`. The same layout applies to `mem_rdata` and `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_ns | input | 1 | Current world: 1 normal, 0 secure |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_ns | output | 1 | World bit carried by the transfer |
| mem_line | output | 12 | Line address (tag and set) |
| mem_wdata | output | 128 | Write-back line data |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 128 | Fill line data, valid with `mem_ack` |

## Verification
The assertions take two things for granted about the processor side. Once `cpu_valid` is high, the processor keeps the address, store flag, data and world bit unchanged until `cpu_ready` is seen. This matters most for the check that a fill carries the requester's world and the check that a completed fill hits in the next cycle. On the memory side, they take for granted that `mem_ack` pulses for one cycle, only while `mem_req` is high, with fill data alongside it. The bench's access task holds every processor input from presentation until the completing edge. Its memory responder raises the acknowledge only in answer to a pending request, two cycles after it, and drops it in the following cycle. It also sweeps every set in both worlds with six tags, more than the ways can hold, so evictions of either world's lines happen throughout the run.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   // Controller phases: reset-time sweep, lookup, dirty eviction, line fill.
   typedef enum logic [1:0] {
      PH_SWEEP = 2'd0,
      PH_LOOK  = 2'd1,
      PH_EVICT = 2'd2,
      PH_FILL  = 2'd3
   } wtc_phase_t;

   // Next round-robin position for a pointer over n ways.
   function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   parameter int IDX_W = $clog2(SETS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   // lookup
   input  logic [IDX_W-1:0]             lk_idx,
   input  logic [TAG_W-1:0]             lk_tag,
   input  logic                         lk_ns,
   output logic [WAYS-1:0]              hit_vec,
   output logic [WAYS-1:0]              way_valid,
   output logic [WAYS-1:0]              way_dirty,
   output logic [WAYS-1:0]              way_ns,
   output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   // sweep clear
   input  logic                         clr_en,
   input  logic [IDX_W-1:0]             clr_idx,
   // allocation
   input  logic                         alloc_en,
   input  logic [WAY_W-1:0]             alloc_way,
   input  logic [TAG_W-1:0]             alloc_tag,
   input  logic                         alloc_ns,
   // store marks line dirty
   input  logic                         mark_en,
   input  logic [WAY_W-1:0]             mark_way
);

   logic [WAYS-1:0]            valid_q [SETS];
   logic [WAYS-1:0]            dirty_q [SETS];
   logic [WAYS-1:0]            ns_q    [SETS];
   logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];

   always_ff @(posedge clk) begin
      if (clr_en) begin
         valid_q[clr_idx] <= '0;
         dirty_q[clr_idx] <= '0;
      end else begin
         if (alloc_en) begin
            valid_q[lk_idx][alloc_way] <= 1'b1;
            dirty_q[lk_idx][alloc_way] <= 1'b0;
            ns_q[lk_idx][alloc_way]    <= alloc_ns;
            tag_q[lk_idx][alloc_way]   <= alloc_tag;
         end
         if (mark_en) begin
            dirty_q[lk_idx][mark_way] <= 1'b1;
         end
      end
   end

   assign way_valid = valid_q[lk_idx];
   assign way_dirty = dirty_q[lk_idx];
   assign way_ns    = ns_q[lk_idx];
   assign way_tag   = tag_q[lk_idx];

   // Tag and world bit together form the match key.
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == lk_tag) && (way_ns[w] == lk_ns);
   end

   // R9: a line is only ever marked dirty when it is already resident.
   a_r9_mark_valid: assert property (@(posedge clk) disable iff (!rst_n)
      mark_en |-> way_valid[mark_way]);

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int LINE_W = 128,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(SETS),
   parameter int WAY_W  = $clog2(WAYS),
   parameter int WSEL_W = $clog2(LINE_W / DATA_W)
) (
   input  logic                          clk,
   input  logic [IDX_W-1:0]              idx,
   output logic [WAYS-1:0][LINE_W-1:0]   way_line,
   input  logic                          fill_en,
   input  logic [WAY_W-1:0]              fill_way,
   input  logic [LINE_W-1:0]             fill_line,
   input  logic                          st_en,
   input  logic [WAY_W-1:0]              st_way,
   input  logic [WSEL_W-1:0]             st_word,
   input  logic [DATA_W-1:0]             st_data
);

   logic [LINE_W-1:0] line_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (fill_en) begin
         line_q[idx][fill_way] <= fill_line;
      end else if (st_en) begin
         line_q[idx][st_way][st_word*DATA_W +: DATA_W] <= st_data;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign way_line[w] = line_q[idx][w];
   end

endmodule

// File: rtl/wtc_victim_rr.sv
module wtc_victim_rr #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int IDX_W = $clog2(SETS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             adv,
   output logic [WAY_W-1:0] victim
);
   import wtc_pkg::*;

   logic [WAY_W-1:0] ptr_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (adv) begin
         ptr_q[idx] <= WAY_W'(rr_next(int'(ptr_q[idx]), WAYS));
      end
   end

   assign victim = ptr_q[idx];

   // R10: a fill moves the addressed set's pointer one step on.
   a_r10_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ptr_q[$past(idx)] == WAY_W'(rr_next(int'($past(victim)), WAYS)));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl #(
   parameter int SETS  = 16,
   parameter int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic             hit,
   input  logic             victim_dirty,
   input  logic             mem_ack,
   output logic             sweep_en,
   output logic [IDX_W-1:0] sweep_idx,
   output logic             req,
   output logic             req_we,
   output logic             fill_done,
   output logic             done
);
   import wtc_pkg::*;

   wtc_phase_t       ph_q, ph_d;
   logic [IDX_W-1:0] cnt_q;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_SWEEP: if (cnt_q == IDX_W'(SETS - 1)) ph_d = PH_LOOK;
         PH_LOOK:  if (cpu_valid && !hit) ph_d = victim_dirty ? PH_EVICT : PH_FILL;
         PH_EVICT: if (mem_ack) ph_d = PH_FILL;
         PH_FILL:  if (mem_ack) ph_d = PH_LOOK;
         default:  ph_d = PH_SWEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_SWEEP;
         cnt_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_SWEEP) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sweep_en  = (ph_q == PH_SWEEP);
   assign sweep_idx = cnt_q;
   assign req       = (ph_q == PH_EVICT) || (ph_q == PH_FILL);
   assign req_we    = (ph_q == PH_EVICT);
   assign fill_done = (ph_q == PH_FILL) && mem_ack;
   assign done      = (ph_q == PH_LOOK) && cpu_valid && hit;

   // R6: a write-back is always followed directly by the fill.
   a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (req && req_we && mem_ack) |=> (req && !req_we));

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LADDR_W   = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_valid,
   input  logic               cpu_we,
   input  logic               cpu_ns,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic               mem_ns,
   output logic [LADDR_W-1:0] mem_line,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic               mem_ack,
   input  logic [LINE_W-1:0]  mem_rdata
);

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORDS  = LINE_W / DATA_W;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);

   initial begin
      assert (WAYS >= 2);
      assert ((1 << IDX_W) == SETS);
      assert ((1 << OFF_W) == LINE_BYTES);
      assert (WORDS >= 2 && (1 << WSEL_W) == WORDS);
      assert (TAG_W >= 1);
   end

   // Address fields
   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic [WSEL_W-1:0] a_word;
   logic              unused_lane;

   assign a_idx       = cpu_addr[OFF_W +: IDX_W];
   assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_word      = cpu_addr[BYTE_W +: WSEL_W];
   assign unused_lane = ^cpu_addr[BYTE_W-1:0];

   // Interconnect
   logic [WAYS-1:0]             hit_vec, w_valid, w_dirty, w_ns;
   logic [WAYS-1:0][TAG_W-1:0]  w_tag;
   logic [WAYS-1:0][LINE_W-1:0] w_line;
   logic [WAY_W-1:0]            hit_way, vic_way;
   logic                        hit, vic_dirty;
   logic                        sweep_en, fill_done, done, req_we;
   logic [IDX_W-1:0]            sweep_idx;
   logic [LINE_W-1:0]           hit_line;

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign vic_dirty = w_valid[vic_way] && w_dirty[vic_way];

   wtc_tag_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (a_idx),
      .lk_tag    (a_tag),
      .lk_ns     (cpu_ns),
      .hit_vec   (hit_vec),
      .way_valid (w_valid),
      .way_dirty (w_dirty),
      .way_ns    (w_ns),
      .way_tag   (w_tag),
      .clr_en    (sweep_en),
      .clr_idx   (sweep_idx),
      .alloc_en  (fill_done),
      .alloc_way (vic_way),
      .alloc_tag (a_tag),
      .alloc_ns  (cpu_ns),
      .mark_en   (done && cpu_we),
      .mark_way  (hit_way)
   );

   wtc_data_store #(
      .SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .DATA_W(DATA_W),
      .IDX_W(IDX_W), .WAY_W(WAY_W), .WSEL_W(WSEL_W)
   ) u_data (
      .clk       (clk),
      .idx       (a_idx),
      .way_line  (w_line),
      .fill_en   (fill_done),
      .fill_way  (vic_way),
      .fill_line (mem_rdata),
      .st_en     (done && cpu_we),
      .st_way    (hit_way),
      .st_word   (a_word),
      .st_data   (cpu_wdata)
   );

   wtc_victim_rr #(
      .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
   ) u_rr (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (a_idx),
      .adv    (fill_done),
      .victim (vic_way)
   );

   wtc_ctrl #(
      .SETS(SETS), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_valid    (cpu_valid),
      .hit          (hit),
      .victim_dirty (vic_dirty),
      .mem_ack      (mem_ack),
      .sweep_en     (sweep_en),
      .sweep_idx    (sweep_idx),
      .req          (mem_req),
      .req_we       (req_we),
      .fill_done    (fill_done),
      .done         (done)
   );

   // Processor side
   assign hit_line  = w_line[hit_way];
   assign cpu_ready = done;
   assign cpu_rdata = hit_line[a_word*DATA_W +: DATA_W];

   // Memory side: a write-back names the victim's own tag and world.
   assign mem_we    = req_we;
   assign mem_line  = req_we ? {w_tag[vic_way], a_idx} : {a_tag, a_idx};
   assign mem_ns    = req_we ? w_ns[vic_way] : cpu_ns;
   assign mem_wdata = w_line[vic_way];

   // R2: the world-qualified tag never matches two ways of one set.
   a_r2_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid |-> $onehot0(hit_vec));

   // R5: a fill is issued under the requesting world.
   a_r5_fill_world: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_ns == cpu_ns));

   // R7: a request stays up until it is acknowledged.
   a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   // R8: the processor is held while any line transfer is pending.
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready);

   // R8: the cycle after a fill completes, the held access hits.
   a_r8_fill_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> cpu_ready);

endmodule

// File: tb/wtc_cache_test.sv
module wtc_cache_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_valid = 1'b0, cpu_we = 1'b0, cpu_ns = 1'b0;
   logic [15:0]  cpu_addr = '0;
   logic [31:0]  cpu_wdata = '0;
   logic         cpu_ready;
   logic [31:0]  cpu_rdata;
   logic         mem_req, mem_we, mem_ns;
   logic [11:0]  mem_line;
   logic [127:0] mem_wdata;
   logic         mem_ack = 1'b0;
   logic [127:0] mem_rdata = '0;

   always #10 clk = ~clk;

   wtc_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_ns(cpu_ns),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_ns(mem_ns),
      .mem_line(mem_line), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_chk = 0, n_bad = 0;
   int n_fill = 0, n_wb = 0;
   logic        wb_ns, fill_ns;
   logic [11:0] wb_line, fill_line;
   logic [127:0] wb_data;
   logic [127:0] bmem [int];
   logic [31:0]  model [int];
   logic [1:0]   lat = '0;
   bit           done_flag = 0;

   function automatic logic [31:0] pat(input logic ns, input logic [11:0] ln, input logic [1:0] w);
      return {7'h35, ns, 6'd0, w, 4'd0, ln};
   endfunction

   function automatic logic [127:0] backing(input logic ns, input logic [11:0] ln);
      int k = {ns, ln};
      logic [127:0] l;
      if (bmem.exists(k)) return bmem[k];
      for (int w = 0; w < 4; w++) l[32*w +: 32] = pat(ns, ln, 2'(w));
      return l;
   endfunction

   function automatic logic [31:0] expect_rd(input logic ns, input logic [15:0] a);
      int k = {ns, a[15:2]};
      if (model.exists(k)) return model[k];
      return pat(ns, a[15:4], a[3:2]);
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Memory responder: ack two cycles after a request, for one cycle.
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (rst_n && mem_req) begin
         if (lat == 2'd1) begin
            lat     <= '0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               bmem[{mem_ns, mem_line}] = mem_wdata;
               n_wb++; wb_ns = mem_ns; wb_line = mem_line; wb_data = mem_wdata;
            end else begin
               mem_rdata <= backing(mem_ns, mem_line);
               n_fill++; fill_ns = mem_ns; fill_line = mem_line;
            end
         end else begin
            lat <= lat + 2'd1;
         end
      end
   end

   task automatic access(input bit we, input bit ns, input logic [15:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_ns = ns; cpu_addr = a; cpu_wdata = wd;
      cyc = 0;
      #1;
      while (!cpu_ready && cyc < 200) begin
         @(negedge clk); #1; cyc++;
      end
      if (cyc >= 200) chk("R8 access stalled", 0, 1);
      rd = cpu_rdata;
      if (we) model[{ns, a[15:2]}] = wd;
      @(posedge clk); #1;
      cpu_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input bit ns, input logic [15:0] a, output int cyc);
      logic [31:0] r;
      access(0, ns, a, 0, r, cyc);
      chk(req, r, expect_rd(ns, a));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int cyc, f0, w0;
      logic [31:0] r;
      repeat (3) @(negedge clk);
      chk("R1 req low in reset", mem_req, 0);
      chk("R1 ready low in reset", cpu_ready, 0);
      @(negedge clk); rst_n = 1'b1;

      // R1: first access waits out the sweep and misses
      rd_chk("R1 first read data", 0, 16'h0010, cyc);
      chk("R1 sweep holds ready", cyc >= 16, 1);
      chk("R1 first access misses", n_fill, 1);
      chk("R5 fill line", fill_line, 12'h001);
      chk("R5 fill world", fill_ns, 0);

      // R8/R12: hits complete at once, word selection
      for (int w = 0; w < 4; w++) begin
         rd_chk("R12 word select", 0, 16'h0010 + 16'(4*w), cyc);
         chk("R8 hit in one cycle", cyc, 0);
      end
      chk("R8 no traffic on hits", n_fill, 1);

      // R3: other world misses and fills under its own bit
      rd_chk("R3 other world data", 1, 16'h0010, cyc);
      chk("R3 other world misses", n_fill, 2);
      chk("R3 fill world bit", fill_ns, 1);

      // R4: alternate worlds, no loss
      for (int i = 0; i < 6; i++) begin
         rd_chk("R4 alternate data", i[0], 16'h0018, cyc);
         chk("R4 alternate hits", cyc, 0);
      end
      chk("R4 no refills", n_fill, 2);

      // R9: store hit
      access(1, 0, 16'h0014, 32'hDEAD_0001, r, cyc);
      chk("R9 store hit one cycle", cyc, 0);
      chk("R9 store no traffic", n_fill + n_wb, 2);
      rd_chk("R9 store readback", 0, 16'h0014, cyc);
      rd_chk("R3 other world unaffected", 1, 16'h0014, cyc);

      // R10/R6/R11: set 1 has ways 0 (ns0, dirty), 1 (ns1); fill 2 more
      rd_chk("R10 fill way2", 0, 16'h0110, cyc);
      rd_chk("R10 fill way3", 0, 16'h0210, cyc);
      chk("R11 no wb into empty ways", n_wb, 0);
      rd_chk("R10 cross-world eviction fill", 1, 16'h0310, cyc);
      chk("R6 dirty victim written", n_wb, 1);
      chk("R6 wb keeps stored world", wb_ns, 0);
      chk("R6 wb line", wb_line, 12'h001);
      chk("R12 wb word1", wb_data[63:32], 32'hDEAD_0001);
      chk("R12 wb word0", wb_data[31:0], pat(0, 12'h001, 2'd0));
      // next victim: way1 (ns1 clean)
      w0 = n_wb; f0 = n_fill;
      rd_chk("R6 written data returns", 0, 16'h0014, cyc);
      chk("R11 clean victim no wb", n_wb, w0);
      chk("R10 refill", n_fill, f0 + 1);
      f0 = n_fill;
      rd_chk("R10 evicted other world line", 1, 16'h0010, cyc);
      chk("R10 other world line was evicted", n_fill, f0 + 1);

      // R9: store miss allocates
      f0 = n_fill;
      access(1, 1, 16'h2008, 32'h0BAD_F00D, r, cyc);
      chk("R9 store miss fills", n_fill, f0 + 1);
      chk("R8 miss holds ready", cyc > 0, 1);
      rd_chk("R9 store miss merged", 1, 16'h2008, cyc);
      rd_chk("R9 neighbour word kept", 1, 16'h200C, cyc);

      // Sweep: every set, both worlds, six tags per set
      for (int p = 0; p < 2; p++) begin
         for (int ns = 0; ns < 2; ns++) begin
            for (int s = 0; s < 16; s++) begin
               for (int t = 0; t < 6; t++) begin
                  logic [15:0] a = {8'(t * 7 + 64), 4'(s), 2'(t + p), 2'b00};
                  if (((t + s + ns + p) % 3) == 0)
                     access(1, ns[0], a, {8'(p), 8'(ns), 8'(s), 8'(t)}, r, cyc);
                  else
                     rd_chk("R2 sweep read", ns[0], a, cyc);
               end
            end
         end
      end
      for (int ns = 0; ns < 2; ns++)
         for (int s = 0; s < 16; s++)
            for (int t = 0; t < 6; t++)
               for (int w = 0; w < 4; w++)
                  rd_chk("R3 sweep final", ns[0], {8'(t * 7 + 64), 4'(s), 2'(w), 2'b00}, cyc);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule